// File: doc/BRIEF.md
# Converter Register Serial Port

This block is a three-wire serial slave through which a host reaches the registers of a data converter. The host lowers chip select and shifts bits in on SDI, sampled on the rising edge of SCLK. Each transaction opens with an 8-bit command byte. A command with its top bit clear names a 24-bit register to read or write, and exactly one 24-bit data word follows, MSB first. A command with its top bit set starts a conversion or calibration action and carries a setup pointer. No data word follows an action, so the next byte in the same frame is again a command.

The register file holds one configuration word and an offset word and a gain word for every input channel. The latest conversion result, supplied by the converter engine, is read through the same port. The calibration arithmetic and the conversion engine are outside this block. They take the register contents as flat buses and the decoded action as a one-cycle strobe.

SCLK, SDI and chip select are synchronised into the system clock domain. The system clock must run at least four times faster than SCLK. The control FSM has four states. `ST_HOLD` is the power-on hold and moves to `ST_CMD` after `POR_CYCLES` clocks. `ST_CMD` collects the command byte. On the eighth bit it goes to `ST_WDATA` for a write, to `ST_RDATA` for a read, or stays in `ST_CMD` for an action. `ST_WDATA` and `ST_RDATA` return to `ST_CMD` after the 24th data bit, or at once when chip select is released.

Top module: `adc_regport`

## Requirements
- R1: After reset, the configuration and offset registers read zero, every gain register reads 0x400000, and `sdo_oe` is low.
- R2: For `POR_CYCLES` (default 2006) clocks after reset, serial traffic is ignored, and a write sent in that window changes no register.
- R3: Command bit 7 = 0 with bit 6 = 0 is a write to the register whose index is bits 5:0. The 24 following bits, MSB first and sampled on SCLK rising edges, are committed after the 24th bit.
- R4: Command bit 7 = 0 with bit 6 = 1 is a read. The register value appears on `sdo` MSB first. The first bit appears after the SCLK falling edge that follows the eighth command bit, and each later bit appears after the next falling edge.
- R5: Register index map: 0 is the configuration register. 1 is the conversion result, which is read-only, so a write to it has no effect. 2+2k is the offset of channel k and 3+2k is the gain of channel k. Any other index reads zero, and a write to it changes nothing.
- R6: Configuration bits 23:17 are not stored. They are dropped on write and read back as zero.
- R7: `chop_div` decodes configuration bits 1:0 as follows: 00 gives 128, 01 gives 8, 10 gives 2 and 11 gives 32.
- R8: Command bit 7 = 1 raises `act_stb` for one clock, with `act_kind` = bits 6:4 and `act_ptr` = bits 3:0. No data word follows it, and the next byte in the frame is decoded as a command.
- R9: Raising `cs_n` before a word is complete aborts the transaction. No register is updated, and the next frame starts with a command byte.
- R10: `sdo_oe` is high only while a read data word is being shifted out with chip select low, and it drops once `cs_n` is high.
- R11: `offset_q` and `gain_q` present channel k's registers in bits [24k+23:24k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, valid when `sdo_oe` is high |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| conv_data | input | 24 | Latest conversion result from the engine |
| cfg_q | output | 24 | Configuration register |
| chop_div | output | 8 | Chop clock divide ratio |
| offset_q | output | 24*NCH | Per-channel offset registers, flattened |
| gain_q | output | 24*NCH | Per-channel gain registers, flattened |
| act_stb | output | 1 | One-cycle action strobe |
| act_kind | output | 3 | Action code |
| act_ptr | output | 4 | Setup pointer of the action |

## Verification
The assertions assume that SCLK stays in each level for at least two system clocks. Under that condition a rising edge and a falling edge never fall into the same clock, and the bit counter never passes the end of a word. The stimulus holds each SCLK level for eight clocks. It changes SDI and chip select only while SCLK is low, well before the next rising edge. It keeps chip select high for several clocks between frames, so every abort and every frame start is seen by the synchroniser.

// File: rtl/acp_pkg.sv
package acp_pkg;
    localparam int WORD_W = 24;
    localparam int CMD_W  = 8;
    localparam int IDX_W  = 6;
    localparam int KIND_W = 3;
    localparam int PTR_W  = 4;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_CMD,
        ST_WDATA,
        ST_RDATA
    } port_state_t;

    function automatic logic [7:0] chop_ratio(input logic [1:0] sel);
        unique case (sel)
            2'b00: return 8'd128;
            2'b01: return 8'd8;
            2'b10: return 8'd2;
            2'b11: return 8'd32;
        endcase
    endfunction
endpackage

// File: rtl/acp_sync.sv
module acp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_q,
    output logic cs_act
);
    logic [STAGES:0]   sclk_p;
    logic [STAGES-1:0] sdi_p;
    logic [STAGES-1:0] cs_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            sdi_p  <= '0;
            cs_p   <= '1;
        end else begin
            sclk_p <= {sclk_p[STAGES-1:0], sclk};
            sdi_p  <= {sdi_p[STAGES-2:0], sdi};
            cs_p   <= {cs_p[STAGES-2:0], cs_n};
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
    assign sdi_q     = sdi_p[STAGES-1];
    assign cs_act    = ~cs_p[STAGES-1];
endmodule

// File: rtl/acp_regfile.sv
module acp_regfile
    import acp_pkg::*;
#(
    parameter int               NCH      = 4,
    parameter logic [WORD_W-1:0] CFG_MASK = 24'h01FFFF,
    parameter logic [WORD_W-1:0] GAIN_RST = 24'h400000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [WORD_W-1:0]     conv_data,
    output logic [WORD_W-1:0]     rdata,
    output logic [WORD_W-1:0]     cfg_q,
    output logic [NCH*WORD_W-1:0] offset_q,
    output logic [NCH*WORD_W-1:0] gain_q
);
    logic [WORD_W-1:0] cfg_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cfg_r <= '0;
        else if (wr_en && idx == IDX_W'(0))     cfg_r <= wdata & CFG_MASK;
    end
    assign cfg_q = cfg_r;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic [WORD_W-1:0] off_r;
        logic [WORD_W-1:0] gain_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_r  <= '0;
                gain_r <= GAIN_RST;
            end else if (wr_en) begin
                if (idx == IDX_W'(2 + 2 * k)) off_r  <= wdata;
                if (idx == IDX_W'(3 + 2 * k)) gain_r <= wdata;
            end
        end
        assign offset_q[k*WORD_W +: WORD_W] = off_r;
        assign gain_q[k*WORD_W +: WORD_W]   = gain_r;
    end

    always_comb begin
        rdata = '0;
        if (idx == IDX_W'(0))      rdata = cfg_r;
        else if (idx == IDX_W'(1)) rdata = conv_data;
        else begin
            for (int k = 0; k < NCH; k++) begin
                if (idx == IDX_W'(2 + 2 * k)) rdata = offset_q[k*WORD_W +: WORD_W];
                if (idx == IDX_W'(3 + 2 * k)) rdata = gain_q[k*WORD_W +: WORD_W];
            end
        end
    end

    // R6
    cfg_undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_r & ~CFG_MASK) == '0);

    // R9
    no_wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_r));
endmodule

// File: rtl/adc_regport.sv
module adc_regport
    import acp_pkg::*;
#(
    parameter int                NCH         = 4,
    parameter int                POR_CYCLES  = 2006,
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] CFG_MASK    = 24'h01FFFF,
    parameter logic [WORD_W-1:0] GAIN_RST    = 24'h400000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdi,
    output logic                  sdo,
    output logic                  sdo_oe,
    input  logic [WORD_W-1:0]     conv_data,
    output logic [WORD_W-1:0]     cfg_q,
    output logic [7:0]            chop_div,
    output logic [NCH*WORD_W-1:0] offset_q,
    output logic [NCH*WORD_W-1:0] gain_q,
    output logic                  act_stb,
    output logic [KIND_W-1:0]     act_kind,
    output logic [PTR_W-1:0]      act_ptr
);
    localparam int POR_W = $clog2(POR_CYCLES + 1);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic sclk_rise, sclk_fall, sdi_q, cs_act;

    acp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_q(sdi_q), .cs_act(cs_act)
    );

    port_state_t          state_q, state_d;
    logic [POR_W-1:0]     por_cnt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [WORD_W-2:0]    sh_in;
    logic [IDX_W-1:0]     idx_q;
    logic [WORD_W-1:0]    out_q;
    logic                 load_pend;
    logic [CMD_W-1:0]     cmd_byte;
    logic [WORD_W-1:0]    wdata, rdata;
    logic                 last_bit, wr_en, cmd_done;

    assign cmd_byte = {sh_in[CMD_W-2:0], sdi_q};
    assign wdata    = {sh_in, sdi_q};
    assign last_bit = (state_q == ST_CMD) ? (bit_cnt == CNT_W'(CMD_W - 1))
                                          : (bit_cnt == CNT_W'(WORD_W - 1));
    assign cmd_done = (state_q == ST_CMD) && cs_act && sclk_rise && last_bit;
    assign wr_en    = (state_q == ST_WDATA) && cs_act && sclk_rise && last_bit;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (por_cnt == POR_W'(POR_CYCLES - 1)) state_d = ST_CMD;
            ST_CMD:   if (cmd_done && !cmd_byte[7])
                          state_d = cmd_byte[6] ? ST_RDATA : ST_WDATA;
            ST_WDATA,
            ST_RDATA: if (!cs_act || (sclk_rise && last_bit)) state_d = ST_CMD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por_cnt   <= '0;
            bit_cnt   <= '0;
            sh_in     <= '0;
            idx_q     <= '0;
            out_q     <= '0;
            load_pend <= 1'b0;
            act_stb   <= 1'b0;
            act_kind  <= '0;
            act_ptr   <= '0;
        end else begin
            act_stb <= 1'b0;
            if (state_q == ST_HOLD) begin
                por_cnt <= por_cnt + 1'b1;
                bit_cnt <= '0;
            end else if (!cs_act) begin
                bit_cnt   <= '0;
                load_pend <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    sh_in   <= {sh_in[WORD_W-3:0], sdi_q};
                    bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                end
                if (cmd_done) begin
                    if (cmd_byte[7]) begin
                        act_stb  <= 1'b1;
                        act_kind <= cmd_byte[6:4];
                        act_ptr  <= cmd_byte[3:0];
                    end else begin
                        idx_q     <= cmd_byte[IDX_W-1:0];
                        load_pend <= cmd_byte[6];
                    end
                end
                if (sclk_fall && state_q == ST_RDATA) begin
                    if (load_pend) begin
                        out_q     <= rdata;
                        load_pend <= 1'b0;
                    end else begin
                        out_q <= {out_q[WORD_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sdo_oe   = cs_act && (state_q == ST_RDATA);
    assign sdo      = sdo_oe ? out_q[WORD_W-1] : 1'b0;
    assign chop_div = chop_ratio(cfg_q[1:0]);

    acp_regfile #(.NCH(NCH), .CFG_MASK(CFG_MASK), .GAIN_RST(GAIN_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx_q), .wdata(wdata),
        .conv_data(conv_data), .rdata(rdata), .cfg_q(cfg_q),
        .offset_q(offset_q), .gain_q(gain_q)
    );

    // R8
    act_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |=> !act_stb);

    // R2
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (!act_stb && !wr_en));

    // R3
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(WORD_W));
endmodule

// File: tb/tb_adc_regport.sv
module tb_adc_regport;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NCH        = 4;
    localparam logic [23:0] CONV = 24'hA5C3E1;

    logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
    logic sdo, sdo_oe, act_stb;
    logic [23:0] cfg_q;
    logic [7:0]  chop_div;
    logic [NCH*24-1:0] offset_q, gain_q;
    logic [2:0] act_kind;
    logic [3:0] act_ptr;
    int n_chk = 0, n_fail = 0, act_cnt = 0;
    logic [2:0] seen_kind;
    logic [3:0] seen_ptr;
    logic oe_seen, rd_oe_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_regport dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .conv_data(CONV), .cfg_q(cfg_q),
        .chop_div(chop_div), .offset_q(offset_q), .gain_q(gain_q),
        .act_stb(act_stb), .act_kind(act_kind), .act_ptr(act_ptr)
    );

    always @(negedge clk) if (act_stb) begin
        act_cnt++; seen_kind = act_kind; seen_ptr = act_ptr;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic got);
        @(negedge clk); sdi = b;
        repeat (HALF) @(negedge clk);
        got = sdo; oe_seen = sdo_oe;
        sclk = 1;
        repeat (HALF) @(negedge clk);
        sclk = 0;
    endtask

    task automatic xfer(input logic [7:0] cmd, input logic [23:0] wd, input int nc,
                        input int nd, output logic [23:0] rd);
        logic b;
        rd = '0; rd_oe_ok = 1;
        @(negedge clk); cs_n = 0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nc; i++) send_bit(cmd[7-i], b);
        for (int i = 0; i < nd; i++) begin
            send_bit(wd[23-i], b);
            rd = {rd[22:0], b};
            if (!oe_seen) rd_oe_ok = 0;
        end
        repeat (HALF) @(negedge clk); cs_n = 1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] idx, input logic [23:0] v);
        logic [23:0] d;
        xfer({2'b00, idx}, v, 8, 24, d);
    endtask

    task automatic rd_reg(input logic [5:0] idx, output logic [23:0] v);
        xfer({2'b01, idx}, 24'h0, 8, 24, v);
    endtask

    task automatic t_reset;
        chk("R1 sdo_oe", sdo_oe, 0);
        chk("R1 cfg", cfg_q, 0);
        chk("R1 offset0", offset_q[23:0], 0);
        chk("R1 gain3", gain_q[95:72], 24'h400000);
        chk("R7 chop 00", chop_div, 128);
    endtask

    task automatic t_hold;
        wr(6'd0, 24'h00ABCD);
        chk("R2 write in hold", cfg_q, 0);
        repeat (2100) @(negedge clk);
        chk("R2 after hold", cfg_q, 0);
    endtask

    task automatic t_cfg;
        logic [23:0] v;
        wr(6'd0, 24'hFFFFFF);
        chk("R6 cfg masked", cfg_q, 24'h01FFFF);
        rd_reg(6'd0, v);
        chk("R6 cfg readback", v, 24'h01FFFF);
        chk("R10 oe during read", rd_oe_ok, 1);
        chk("R10 oe after cs", sdo_oe, 0);
        chk("R7 chop 11", chop_div, 32);
        wr(6'd0, 24'h000001); chk("R7 chop 01", chop_div, 8);
        wr(6'd0, 24'h000002); chk("R7 chop 10", chop_div, 2);
        wr(6'd0, 24'h012340);
        rd_reg(6'd0, v);
        chk("R4 cfg pattern", v, 24'h012340);
        chk("R7 chop back 00", chop_div, 128);
    endtask

    task automatic t_banks;
        logic [23:0] v;
        for (int k = 0; k < NCH; k++) begin
            wr(6'(2 + 2*k), 24'h100000 + 24'(k * 24'h1111));
            wr(6'(3 + 2*k), 24'h7F0000 ^ 24'(k));
        end
        for (int k = 0; k < NCH; k++) begin
            rd_reg(6'(2 + 2*k), v);
            chk("R5 offset read", v, 24'h100000 + 24'(k * 24'h1111));
            rd_reg(6'(3 + 2*k), v);
            chk("R4 gain read", v, 24'h7F0000 ^ 24'(k));
            chk("R11 offset bus", offset_q[k*24 +: 24], 24'h100000 + 24'(k * 24'h1111));
            chk("R11 gain bus", gain_q[k*24 +: 24], 24'h7F0000 ^ 24'(k));
        end
    endtask

    task automatic t_index;
        logic [23:0] v;
        rd_reg(6'd1, v);
        chk("R5 conv read", v, CONV);
        wr(6'd1, 24'h000000);
        rd_reg(6'd1, v);
        chk("R5 conv read-only", v, CONV);
        wr(6'd20, 24'hFFFFFF);
        rd_reg(6'd20, v);
        chk("R5 unmapped reads zero", v, 0);
        rd_reg(6'd2, v);
        chk("R5 unmapped write no effect", v, 24'h100000);
    endtask

    task automatic t_abort;
        logic [23:0] v;
        wr(6'd0, 24'h000005);
        xfer({2'b00, 6'd0}, 24'h0AAAAA, 8, 12, v);
        chk("R9 abort data", cfg_q, 24'h000005);
        xfer({2'b01, 6'd0}, 24'h0, 4, 0, v);
        rd_reg(6'd0, v);
        chk("R9 abort in command", v, 24'h000005);
    endtask

    task automatic t_action;
        logic b;
        int c0;
        logic [7:0] wc;
        logic [23:0] d;
        c0 = act_cnt; wc = {2'b00, 6'd2}; d = 24'h3C3C3C;
        @(negedge clk); cs_n = 0;
        repeat (4) @(negedge clk);
        for (int i = 7; i >= 0; i--) send_bit(8'hD9 >> i, b);
        for (int i = 7; i >= 0; i--) send_bit(wc[i], b);
        for (int i = 23; i >= 0; i--) send_bit(d[i], b);
        repeat (HALF) @(negedge clk); cs_n = 1;
        repeat (8) @(negedge clk);
        chk("R8 one strobe", act_cnt - c0, 1);
        chk("R8 kind", seen_kind, 3'd5);
        chk("R8 ptr", seen_ptr, 4'd9);
        chk("R8 chained write", offset_q[23:0], 24'h3C3C3C);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_hold;
        t_cfg;
        t_banks;
        t_index;
        t_abort;
        t_action;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule